// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer between two unrelated clocks. A producer writes 9-bit words on the write clock and a consumer takes them on the read clock. There are 256 words of storage. Four active-low status outputs report the fill state: empty, full, near-empty and near-full. The two "near" thresholds come from two offset registers. Both offsets reset to 7 and can be changed at run time.

Each side has two enables. On the write side, the second enable has two roles, and the level it holds while reset is asserted picks one for the whole session. If it is held high, it is a plain second write enable. If it is held low, it becomes a load-select line. With load-select high, writes go to the offset registers and reads return their contents. With load-select low, the FIFO works as normal.

The pointers cross between domains as Gray code. The empty and near-empty flags are produced on the read clock. The full and near-full flags are produced on the write clock.

Top module: `afifo_pflag`

## Requirements
- R1: After reset, empty_n and near_empty_n are 0, full_n and near_full_n are 1, and rd_data is 0. Both offset registers hold 7 (the empty offset n and the full offset m).
- R2: Words leave in the order they were written. rd_data takes the new word on the read-clock rising edge that accepts the read, and holds it until the next accepted read.
- R3: With fill level L, once synchronisation has settled: L = 0 gives empty_n = 0 and near_empty_n = 0. L from 1 to n gives empty_n = 1 and near_empty_n = 0. L above n gives near_empty_n = 1.
- R4: With depth D = 256, once settled: L from D-m to D-1 gives near_full_n = 0 and full_n = 1. L = D gives full_n = 0 and near_full_n = 0. L below D-m gives both high.
- R5: While full_n is 0, a write request is ignored. The write pointer does not advance and no stored word changes.
- R6: While empty_n is 0, a read request is ignored. The read pointer does not advance and rd_data holds its value.
- R7: In normal mode (wr_en2_ld high during reset), a FIFO write needs wr_en = 1 and wr_en2_ld = 1. In both modes, a read needs rd_en = 1 and rd_en2 = 1. A request with only one enable high has no effect.
- R8: In load mode (wr_en2_ld low during reset), wr_en = 1 with wr_en2_ld = 1 stores wr_data[7:0] into an offset register and does not touch the FIFO. Successive loads go to the empty offset, then the full offset, then wrap. wr_en = 1 with wr_en2_ld = 0 is a FIFO write.
- R9: In load mode, an enabled read with wr_en2_ld = 1 returns an offset on rd_data, zero-extended to 9 bits, one read-clock edge later. Successive read-backs give the empty offset, then the full offset, then wrap. The FIFO read pointer does not move.
- R10: Loaded offsets take the place of the defaults in the thresholds of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 9 | Word to write; bits [7:0] carry an offset in load mode |
| wr_en | input | 1 | First write enable |
| wr_en2_ld | input | 1 | Second write enable, or load-select; role fixed by its level during reset |
| rd_en | input | 1 | First read enable |
| rd_en2 | input | 1 | Second read enable |
| rd_data | output | 9 | Registered read word or offset read-back |
| empty_n | output | 1 | Empty, active low, read clock |
| full_n | output | 1 | Full, active low, write clock |
| near_empty_n | output | 1 | Level at or below the empty offset, active low, read clock |
| near_full_n | output | 1 | Level at or above depth minus the full offset, active low, write clock |

## Verification
A write can arrive on the very edge that makes the FIFO full. A read can arrive on the very edge that empties it. In both cases the flag change and the ignored request fall together. The bench fills the FIFO one word at a time to 256 and keeps requesting writes there. It then drains the FIFO to zero and keeps requesting reads. It judges the outcome from the next word and level seen after the blocked requests, and from rd_data holding its value. A second collision is tested in load mode: offset read-back shares the read path with FIFO pops partway through a drain. The bench checks that the read-back returns the next offset in sequence and that the following pop still delivers the expected word.

// File: rtl/afifo_pflag_pkg.sv
package afifo_pflag_pkg;

   // Which offset register the next load access targets
   typedef enum logic {
      SLOT_EMPTY_OFS = 1'b0,
      SLOT_FULL_OFS  = 1'b1
   } ofs_slot_t;

   function automatic ofs_slot_t next_slot(input ofs_slot_t s);
      return (s == SLOT_EMPTY_OFS) ? SLOT_FULL_OFS : SLOT_EMPTY_OFS;
   endfunction

endpackage

// File: rtl/afifo_pflag_sync.sv
module afifo_pflag_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/afifo_pflag_ram.sv
module afifo_pflag_ram #(
   parameter int DATA_W = 9,
   parameter int ADDR_W = 8
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/afifo_pflag_wr.sv
module afifo_pflag_wr
   import afifo_pflag_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int EMPTY_OFS   = 7,
   parameter int FULL_OFS    = 7
) (
   input  logic              wr_clk,
   input  logic              rst_n,
   input  logic              ld_mode,
   input  logic              wr_en,
   input  logic              wr_en2_ld,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic [ADDR_W:0]   rgray_async,
   output logic [ADDR_W:0]   wgray,
   output logic [ADDR_W:0]   wbin,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic              full_n,
   output logic              near_full_n,
   output logic [ADDR_W-1:0] ofs_empty,
   output logic [ADDR_W-1:0] ofs_full
);

   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0]     DEPTH_P    = {1'b1, {ADDR_W{1'b0}}};
   localparam logic [ADDR_W-1:0] EMPTY_INIT = ADDR_W'(EMPTY_OFS);
   localparam logic [ADDR_W-1:0] FULL_INIT  = ADDR_W'(FULL_OFS);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] rgray_s, rbin_s, wbin_nxt, wgray_nxt, lvl_nxt;
   logic          fifo_req, push, load_wr, full_nxt;
   ofs_slot_t     slot;

   afifo_pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray_async), .q(rgray_s)
   );

   assign rbin_s    = g2b(rgray_s);
   assign load_wr   = ld_mode & wr_en & wr_en2_ld;
   assign fifo_req  = ld_mode ? (wr_en & ~wr_en2_ld) : (wr_en & wr_en2_ld);
   assign push      = fifo_req & full_n;
   assign wbin_nxt  = wbin + {{ADDR_W{1'b0}}, push};
   assign wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
   assign full_nxt  = (wgray_nxt == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
   assign lvl_nxt   = wbin_nxt - rbin_s;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin        <= '0;
         wgray       <= '0;
         full_n      <= 1'b1;
         near_full_n <= 1'b1;
      end else begin
         wbin        <= wbin_nxt;
         wgray       <= wgray_nxt;
         full_n      <= ~full_nxt;
         near_full_n <= (lvl_nxt < (DEPTH_P - {1'b0, ofs_full}));
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_empty <= EMPTY_INIT;
         ofs_full  <= FULL_INIT;
         slot      <= SLOT_EMPTY_OFS;
      end else if (load_wr) begin
         if (slot == SLOT_EMPTY_OFS) ofs_empty <= ld_data;
         else                        ofs_full  <= ld_data;
         slot <= next_slot(slot);
      end
   end

   assign mem_we    = push;
   assign mem_waddr = wbin[ADDR_W-1:0];

endmodule

// File: rtl/afifo_pflag_rd.sv
module afifo_pflag_rd
   import afifo_pflag_pkg::*;
#(
   parameter int DATA_W      = 9,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              ld_mode,
   input  logic              rd_en,
   input  logic              rd_en2,
   input  logic              ld_sel,
   input  logic [ADDR_W:0]   wgray_async,
   input  logic [ADDR_W-1:0] ofs_empty,
   input  logic [ADDR_W-1:0] ofs_full,
   input  logic [DATA_W-1:0] mem_q,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic [ADDR_W:0]   rgray,
   output logic [ADDR_W:0]   rbin,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              near_empty_n
);

   localparam int PW = ADDR_W + 1;

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wgray_s, wbin_s, rbin_nxt, rgray_nxt, lvl_nxt;
   logic          strobe, load_rd, pop;
   ofs_slot_t     slot;

   afifo_pflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray_async), .q(wgray_s)
   );

   assign wbin_s    = g2b(wgray_s);
   assign strobe    = rd_en & rd_en2;
   assign load_rd   = strobe & ld_mode & ld_sel;
   assign pop       = strobe & ~(ld_mode & ld_sel) & empty_n;
   assign rbin_nxt  = rbin + {{ADDR_W{1'b0}}, pop};
   assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);
   assign lvl_nxt   = wbin_s - rbin_nxt;

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin         <= '0;
         rgray        <= '0;
         empty_n      <= 1'b0;
         near_empty_n <= 1'b0;
      end else begin
         rbin         <= rbin_nxt;
         rgray        <= rgray_nxt;
         empty_n      <= (rgray_nxt != wgray_s);
         near_empty_n <= (lvl_nxt > {1'b0, ofs_empty});
      end
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         slot    <= SLOT_EMPTY_OFS;
      end else if (pop) begin
         rd_data <= mem_q;
      end else if (load_rd) begin
         rd_data <= (slot == SLOT_EMPTY_OFS) ? DATA_W'(ofs_empty) : DATA_W'(ofs_full);
         slot    <= next_slot(slot);
      end
   end

   assign mem_raddr = rbin[ADDR_W-1:0];

endmodule

// File: rtl/afifo_pflag.sv
module afifo_pflag #(
   parameter int DATA_W      = 9,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int EMPTY_OFS   = 7,
   parameter int FULL_OFS    = 7
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   input  logic              wr_en2_ld,
   input  logic              rd_en,
   input  logic              rd_en2,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              full_n,
   output logic              near_empty_n,
   output logic              near_full_n
);

   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("afifo_pflag: ADDR_W must be 2 or more");
      end
      if (DATA_W < ADDR_W) begin : g_bad_data
         $error("afifo_pflag: DATA_W must hold an offset of ADDR_W bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("afifo_pflag: SYNC_STAGES must be 2 or more");
      end
      if (EMPTY_OFS < 0 || EMPTY_OFS >= DEPTH || FULL_OFS < 0 || FULL_OFS >= DEPTH) begin : g_bad_ofs
         $error("afifo_pflag: default offsets must lie in 0 .. DEPTH-1");
      end
   endgenerate

   logic              ld_mode;
   logic [PW-1:0]     wgray, rgray, wbin, rbin;
   logic [ADDR_W-1:0] ofs_empty, ofs_full, mem_waddr, mem_raddr;
   logic              mem_we;
   logic [DATA_W-1:0] mem_q;

   // Role of wr_en2_ld: transparent while reset is held, frozen on release
   always_latch begin
      if (!rst_n) ld_mode <= ~wr_en2_ld;
   end

   afifo_pflag_wr #(
      .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
      .EMPTY_OFS(EMPTY_OFS), .FULL_OFS(FULL_OFS)
   ) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .ld_mode(ld_mode),
      .wr_en(wr_en), .wr_en2_ld(wr_en2_ld), .ld_data(wr_data[ADDR_W-1:0]),
      .rgray_async(rgray), .wgray(wgray), .wbin(wbin),
      .mem_we(mem_we), .mem_waddr(mem_waddr),
      .full_n(full_n), .near_full_n(near_full_n),
      .ofs_empty(ofs_empty), .ofs_full(ofs_full)
   );

   afifo_pflag_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
      .raddr(mem_raddr), .rdata(mem_q)
   );

   afifo_pflag_rd #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .ld_mode(ld_mode),
      .rd_en(rd_en), .rd_en2(rd_en2), .ld_sel(wr_en2_ld),
      .wgray_async(wgray), .ofs_empty(ofs_empty), .ofs_full(ofs_full),
      .mem_q(mem_q), .mem_raddr(mem_raddr), .rgray(rgray), .rbin(rbin),
      .rd_data(rd_data), .empty_n(empty_n), .near_empty_n(near_empty_n)
   );

endmodule

// File: rtl/afifo_pflag_chk.sv
module afifo_pflag_chk #(
   parameter int ADDR_W = 8
) (
   input logic            wr_clk,
   input logic            rd_clk,
   input logic            rst_n,
   input logic            full_n,
   input logic            near_full_n,
   input logic            empty_n,
   input logic            near_empty_n,
   input logic [ADDR_W:0] wbin,
   input logic [ADDR_W:0] rbin
);

   // R5: a full FIFO keeps its write pointer
   a_r5_full_holds_wptr: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> (wbin == $past(wbin)));

   // R6: an empty FIFO keeps its read pointer
   a_r6_empty_holds_rptr: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> (rbin == $past(rbin)));

   // R3: empty lies inside the near-empty band
   a_r3_empty_within_near: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !near_empty_n);

   // R4: full lies inside the near-full band
   a_r4_full_within_near: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !near_full_n);

   // R2: write pointer steps by at most one word per edge
   a_r2_wptr_single_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
      1'b1 |=> ((wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1)));

   // R2: read pointer steps by at most one word per edge
   a_r2_rptr_single_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
      1'b1 |=> ((rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1)));

endmodule

bind afifo_pflag afifo_pflag_chk #(.ADDR_W(ADDR_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
   .full_n(full_n), .near_full_n(near_full_n),
   .empty_n(empty_n), .near_empty_n(near_empty_n),
   .wbin(wbin), .rbin(rbin)
);

// File: tb/sim_afifo_pflag.sv
`timescale 1ns/1ns
module sim_afifo_pflag;

   localparam int DW    = 9;
   localparam int AW    = 8;
   localparam int DEPTH = 256;

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          rst_n  = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_en = 1'b0, wr_en2_ld = 1'b1, rd_en = 1'b0, rd_en2 = 1'b0;
   logic [DW-1:0] rd_data;
   logic          empty_n, full_n, near_empty_n, near_full_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   afifo_pflag #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_data(wr_data), .wr_en(wr_en), .wr_en2_ld(wr_en2_ld),
      .rd_en(rd_en), .rd_en2(rd_en2), .rd_data(rd_data),
      .empty_n(empty_n), .full_n(full_n),
      .near_empty_n(near_empty_n), .near_full_n(near_full_n)
   );

   // 50 MHz write clock; read clock of 26 ns with odd-time rising edges
   always #10 wr_clk = ~wr_clk;
   initial begin
      #3 rd_clk = 1'b1;
      forever #13 rd_clk = ~rd_clk;
   end

   function automatic int pat_a(input int k);
      return (k * 37 + 5) % 512;
   endfunction

   function automatic int pat_b(input int k);
      return (k * 91 + 200) % 512;
   endfunction

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic do_reset(input bit load_mode);
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rd_en2 = 1'b0;
      wr_en2_ld = ~load_mode;
      repeat (4) @(negedge wr_clk);
      rst_n = 1'b1;
      @(negedge wr_clk);
   endtask

   task automatic wr_pulse(input int d, input bit en2);
      @(negedge wr_clk);
      wr_data = DW'(d); wr_en2_ld = en2; wr_en = 1'b1;
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_pulse(input bit e1, input bit e2);
      @(negedge rd_clk);
      rd_en = e1; rd_en2 = e2;
      @(negedge rd_clk);
      rd_en = 1'b0; rd_en2 = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(negedge wr_clk);
      repeat (5) @(negedge rd_clk);
      @(negedge wr_clk);
   endtask

   task automatic check_level(input int lvl, input int n, input int m, input string pfx);
      chk($sformatf("%s R3 empty_n L=%0d", pfx, lvl), int'(empty_n), (lvl != 0) ? 1 : 0);
      chk($sformatf("%s R3 near_empty_n L=%0d", pfx, lvl), int'(near_empty_n), (lvl > n) ? 1 : 0);
      chk($sformatf("%s R4 full_n L=%0d", pfx, lvl), int'(full_n), (lvl != DEPTH) ? 1 : 0);
      chk($sformatf("%s R4 near_full_n L=%0d", pfx, lvl), int'(near_full_n), (lvl < DEPTH - m) ? 1 : 0);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // ---------------- normal mode ----------------
      do_reset(1'b0);
      chk("R1 empty_n", int'(empty_n), 0);
      chk("R1 near_empty_n", int'(near_empty_n), 0);
      chk("R1 full_n", int'(full_n), 1);
      chk("R1 near_full_n", int'(near_full_n), 1);
      chk("R1 rd_data", int'(rd_data), 0);

      // R6: read on empty changes nothing
      rd_pulse(1'b1, 1'b1);
      chk("R6 rd_data on empty", int'(rd_data), 0);
      settle();
      chk("R6 empty_n after blocked read", int'(empty_n), 0);

      // R7: one write enable alone does not write
      wr_pulse(9'h1AB, 1'b0);
      settle();
      chk("R7 empty_n after half-enabled write", int'(empty_n), 0);
      check_level(0, 7, 7, "A");

      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
         wr_pulse(pat_a(lvl - 1), 1'b1);
         settle();
         check_level(lvl, 7, 7, "A");
         if (lvl == 1) begin
            rd_pulse(1'b1, 1'b0);
            settle();
            chk("R7 level kept after half-enabled read", int'(empty_n), 1);
            chk("R7 rd_data kept after half-enabled read", int'(rd_data), 0);
         end
      end

      // R5: writes while full are dropped
      for (int i = 0; i < 3; i++) wr_pulse(9'h055 + i, 1'b1);
      settle();
      check_level(DEPTH, 7, 7, "R5");

      for (int k = 0; k < DEPTH; k++) begin
         rd_pulse(1'b1, 1'b1);
         chk($sformatf("R2 word %0d", k), int'(rd_data), pat_a(k));
         settle();
         check_level(DEPTH - 1 - k, 7, 7, "A");
      end

      rd_pulse(1'b1, 1'b1);
      chk("R6 rd_data held on empty", int'(rd_data), pat_a(DEPTH - 1));
      settle();
      check_level(0, 7, 7, "R6");

      // ---------------- load mode ----------------
      do_reset(1'b1);
      chk("R1 empty_n load mode", int'(empty_n), 0);
      @(negedge wr_clk) wr_en2_ld = 1'b1;
      rd_pulse(1'b1, 1'b1);
      chk("R1 default empty offset", int'(rd_data), 7);
      rd_pulse(1'b1, 1'b1);
      chk("R1 default full offset", int'(rd_data), 7);

      wr_pulse(9, 1'b1);
      wr_pulse(20, 1'b1);
      wr_pulse(9'h103, 1'b1);   // wraps to the empty offset; bit 8 is not part of it
      rd_pulse(1'b1, 1'b1);
      chk("R8 R9 empty offset after wrap", int'(rd_data), 3);
      rd_pulse(1'b1, 1'b1);
      chk("R9 full offset", int'(rd_data), 20);
      rd_pulse(1'b1, 1'b1);
      chk("R9 read-back wraps", int'(rd_data), 3);
      settle();
      chk("R8 loads leave FIFO empty", int'(empty_n), 0);
      chk("R8 loads leave near_empty_n", int'(near_empty_n), 0);

      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
         wr_pulse(pat_b(lvl - 1), 1'b0);
         settle();
         check_level(lvl, 3, 20, "R10");
      end

      for (int k = 0; k < DEPTH; k++) begin
         if (k == 100) begin
            @(negedge wr_clk) wr_en2_ld = 1'b1;
            rd_pulse(1'b1, 1'b1);
            chk("R9 read-back during drain", int'(rd_data), 20);
            @(negedge wr_clk) wr_en2_ld = 1'b0;
         end
         rd_pulse(1'b1, 1'b1);
         chk($sformatf("R2 load-mode word %0d", k), int'(rd_data), pat_b(k));
         settle();
         check_level(DEPTH - 1 - k, 3, 20, "R10");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule